// File: doc/BRIEF.md
# Compare-Masked Watchdog Timer

This block is a watchdog built around a free-running 16-bit up-counter. The counter advances by one on each cycle where the `tick` enable is high. In the target system, `tick` stands in for a 32768 Hz low-speed clock. A programmable count of ignored upper bits narrows the compare to the low 16−N counter bits, which sets a coarse timeout range. Inside that range, a match value places the event at a fine position.

Each time the masked count equals the masked match value, the block records a match event. The first event after a service sets an interrupt flag. The third event that software fails to service produces a one-cycle reset pulse. To service the watchdog, software writes the clear register. It then usually rewrites the match register as the live count plus an offset, and the compare wraps modulo 2^(16−N).

The control, match and ignore-count registers are protected. A write to them only takes effect after software writes two key values to the key register, one after the other, and each protected write closes the lock again. The block also provides a combinational read port, which returns the count, the control and status word, the match value and the ignore count.

Top module: `cmwd_top`

## Requirements
- R1: After reset, the block is in this state:
  - the count, match value and ignore count read 0;
  - control readback (address 1) is 0, meaning disabled, unmasked, locked, no flag and no events;
  - `irq` and `wdt_reset` are low.
- R2: The counter advances by exactly 1 (mod 2^16) on each `tick` cycle, whether or not the watchdog is enabled. It holds its value when `tick` is low.
- R3: The lock opens when 16'hACE1 and then 16'h51D3 are written to address 0 on consecutive writes. Any other write closes the lock. While the lock is closed, a write to address 1, 2 or 3 leaves that register unchanged.
- R4: While the lock is open, a write to address 1 (bit0 enable, bit1 interrupt mask), address 2 (match) or address 3 (ignore count) takes effect. The lock is then closed, so a second protected write without a new key sequence is ignored.
- R5: An ignore count written above 12 is stored as 12.
- R6: With the watchdog enabled, a match event happens on a tick whose new count, in bits [15−N:0], equals the same bits of the match value. Match bits above that range have no effect.
- R7: The first match event after a clear sets the interrupt flag. `irq` equals the flag gated by the inverse of the mask bit.
- R8: The third match event without a clear raises `wdt_reset` for exactly one cycle, even when the interrupt is masked. The event count then returns to 0.
- R9: A write of any data to address 4 sets the event count and the interrupt flag to 0, whatever the lock state.
- R10: While the watchdog is disabled, the event count stays at 0, no interrupt flag is set and `wdt_reset` stays low.
- R11: A match written as the count plus an offset wraps modulo 2^(16−N). The first event comes exactly `offset` ticks later.
- R12: Reads are combinational:
  - address 0 returns the count;
  - address 2 returns the match value;
  - address 3 returns the ignore count;
  - address 1 returns {events[5:4], flag[3], lock-open[2], mask[1], enable[0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| irq | output | 1 | Match interrupt, masked |
| wdt_reset | output | 1 | One-cycle system reset request |

## Verification
The assertions assume the following about the inputs:
- `tick` and the write strobe are stable, synchronous single-cycle pulses;
- addresses above 4 carry no meaning, apart from closing the lock.

The stimulus drives every input on the falling edge and keeps `tick` low while it programs the registers. As a result, the count read back just before a match write is the count the compare starts from. The event counter also never sees a register change in the same cycle as a tick.

// File: rtl/cmwd_pkg.sv
package cmwd_pkg;
  parameter int CNT_W   = 16;
  parameter int MAX_IGN = 12;
  parameter int IGN_W   = $clog2(MAX_IGN + 1);
  parameter int AW      = 3;

  parameter logic [CNT_W-1:0] KEY_FIRST  = 16'hACE1;
  parameter logic [CNT_W-1:0] KEY_SECOND = 16'h51D3;

  typedef enum logic [AW-1:0] {
    A_KEY   = 3'd0,
    A_CTRL  = 3'd1,
    A_MATCH = 3'd2,
    A_IGN   = 3'd3,
    A_CLEAR = 3'd4
  } addr_e;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_e;

  // Limit a written ignore count to the supported maximum.
  function automatic logic [IGN_W-1:0] ign_clamp(input logic [CNT_W-1:0] d);
    if (d > CNT_W'(MAX_IGN)) return IGN_W'(MAX_IGN);
    return d[IGN_W-1:0];
  endfunction

  // Bits that take part in the compare: the low CNT_W-ign bits.
  function automatic logic [CNT_W-1:0] cmp_mask(input logic [IGN_W-1:0] ign);
    return {CNT_W{1'b1}} >> ign;
  endfunction

  function automatic logic masked_hit(input logic [CNT_W-1:0] a,
                                      input logic [CNT_W-1:0] b,
                                      input logic [IGN_W-1:0] ign);
    return ((a ^ b) & cmp_mask(ign)) == '0;
  endfunction
endpackage

// File: rtl/cmwd_lock.sv
module cmwd_lock
  import cmwd_pkg::*;
#(
  parameter logic [CNT_W-1:0] K1 = KEY_FIRST,
  parameter logic [CNT_W-1:0] K2 = KEY_SECOND
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             key_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             open
);
  lock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      st_d = LK_SHUT;
      if (key_sel && st_q == LK_SHUT && wr_data == K1) st_d = LK_HALF;
      if (key_sel && st_q == LK_HALF && wr_data == K2) st_d = LK_OPEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_SHUT;
    else        st_q <= st_d;
  end

  assign open = (st_q == LK_OPEN);
endmodule

// File: rtl/cmwd_counter.sv
module cmwd_counter
  import cmwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] match,
  input  logic [IGN_W-1:0] ign,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nx;
  end

  assign count = cnt_q;
  assign hit   = tick && masked_hit(cnt_nx, match, ign);
endmodule

// File: rtl/cmwd_events.sv
module cmwd_events #(
  parameter int RESET_EVENTS = 3,
  localparam int EVT_W = $clog2(RESET_EVENTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic             hit,
  output logic [EVT_W-1:0] evt_cnt,
  output logic             flag,
  output logic             rst_pulse
);
  localparam logic [EVT_W-1:0] LAST = EVT_W'(RESET_EVENTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_cnt   <= '0;
      flag      <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= 1'b0;
      if (clear) begin
        evt_cnt <= '0;
        flag    <= 1'b0;
      end else if (!enable) begin
        evt_cnt <= '0;
      end else if (hit) begin
        if (evt_cnt == '0) flag <= 1'b1;
        if (evt_cnt == LAST) begin
          evt_cnt   <= '0;
          rst_pulse <= 1'b1;
        end else begin
          evt_cnt <= evt_cnt + EVT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cmwd_top.sv
module cmwd_top
  import cmwd_pkg::*;
#(
  parameter int RESET_EVENTS = 3,
  localparam int EVT_W = $clog2(RESET_EVENTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq,
  output logic             wdt_reset
);
  logic             en_q, mask_q;
  logic [CNT_W-1:0] match_q;
  logic [IGN_W-1:0] ign_q;
  logic [CNT_W-1:0] cnt;
  logic             match_evt;
  logic             lock_open;
  logic             clr_wr;
  logic             prot_wr;
  logic [EVT_W-1:0] evt_cnt;
  logic             irq_flag;

  assign clr_wr  = wr_en && (wr_addr == A_CLEAR);
  assign prot_wr = wr_en && lock_open;

  cmwd_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .key_sel (wr_addr == A_KEY),
    .wr_data (wr_data),
    .open    (lock_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mask_q  <= 1'b0;
      match_q <= '0;
      ign_q   <= '0;
    end else if (prot_wr) begin
      case (wr_addr)
        A_CTRL:  begin en_q <= wr_data[0]; mask_q <= wr_data[1]; end
        A_MATCH: match_q <= wr_data;
        A_IGN:   ign_q <= ign_clamp(wr_data);
        default: ;
      endcase
    end
  end

  cmwd_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .match (match_q),
    .ign   (ign_q),
    .count (cnt),
    .hit   (match_evt)
  );

  cmwd_events #(.RESET_EVENTS(RESET_EVENTS)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (en_q),
    .clear     (clr_wr),
    .hit       (match_evt),
    .evt_cnt   (evt_cnt),
    .flag      (irq_flag),
    .rst_pulse (wdt_reset)
  );

  assign irq = irq_flag && !mask_q;

  always_comb begin
    case (rd_addr)
      A_KEY:   rd_data = cnt;
      A_CTRL:  rd_data = CNT_W'({evt_cnt, irq_flag, lock_open, mask_q, en_q});
      A_MATCH: rd_data = match_q;
      A_IGN:   rd_data = CNT_W'(ign_q);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cmwd_chk.sv
module cmwd_chk
  import cmwd_pkg::*;
#(
  parameter int EVT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] match_q,
  input logic             match_evt,
  input logic             lock_open,
  input logic             en_q,
  input logic [EVT_W-1:0] evt_cnt,
  input logic             irq_flag,
  input logic             wdt_reset
);
  localparam logic [AW-1:0] MATCH_A = 3'd2;
  localparam logic [AW-1:0] CLEAR_A = 3'd4;
  localparam logic [EVT_W-1:0] LAST_EVT = EVT_W'(2);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick) |-> cnt == CNT_W'($past(cnt) + CNT_W'(1)));
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(cnt));
  // R3
  locked_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MATCH_A && !lock_open) |=> $stable(match_q));
  // R4
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock_open) |=> !lock_open);
  // R7
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(match_evt) && $past(en_q));
  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);
  // R8
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> $past(match_evt) && $past(evt_cnt) == LAST_EVT);
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CLEAR_A) |=> evt_cnt == '0 && !irq_flag);
  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_q) |-> !wdt_reset && evt_cnt == '0);
endmodule

bind cmwd_top cmwd_chk #(.EVT_W(EVT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .cnt       (cnt),
  .match_q   (match_q),
  .match_evt (match_evt),
  .lock_open (lock_open),
  .en_q      (en_q),
  .evt_cnt   (evt_cnt),
  .irq_flag  (irq_flag),
  .wdt_reset (wdt_reset)
);

// File: tb/tb_cmwd_top.sv
module tb_cmwd_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq, wdt_reset;

  int checks = 0, failures = 0;
  int first_irq, first_rst, n_rst;
  int cycles = 0;

  always #4 clk = ~clk;

  cmwd_top dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 3'(a); #1; d = int'(rd_data);
  endtask

  task automatic unlock();
    wr(0, 16'hACE1); wr(0, 16'h51D3);
  endtask

  task automatic pwr(input int a, input int d);
    unlock(); wr(a, d);
  endtask

  task automatic run_ticks(input int n);
    first_irq = -1; first_rst = -1; n_rst = 0;
    for (int i = 1; i <= n; i++) begin
      tick = 1'b1;
      @(posedge clk); @(negedge clk);
      if (irq && first_irq < 0) first_irq = i;
      if (wdt_reset) begin
        n_rst++;
        if (first_rst < 0) first_rst = i;
      end
    end
    tick = 1'b0;
  endtask

  // Program the match as live count plus offset; returns nothing.
  task automatic set_rel_match(input int off, input int upper_xor);
    int c;
    rd(0, c);
    pwr(2, ((c + off) & 16'hFFFF) ^ upper_xor);
  endtask

  task automatic t_reset();
    int v;
    rd(0, v); chk(v == 0, "R1 count", v, 0);
    rd(1, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(2, v); chk(v == 0, "R1 match", v, 0);
    rd(3, v); chk(v == 0, "R1 ignore", v, 0);
    chk(!irq && !wdt_reset, "R1 outputs", int'({irq, wdt_reset}), 0);
  endtask

  task automatic t_count();
    int a, b;
    rd(0, a);
    repeat (5) @(negedge clk);
    rd(0, b); chk(a == b, "R2 hold", b, a);
    run_ticks(9);
    rd(0, b); chk(b == ((a + 9) & 16'hFFFF), "R2 step", b, (a + 9) & 16'hFFFF);
  endtask

  task automatic t_lock();
    int v;
    wr(2, 16'h1234);
    rd(2, v); chk(v == 0, "R3 locked write ignored", v, 0);
    wr(0, 16'hACE1); wr(0, 16'h1111); wr(2, 16'h2222);
    rd(2, v); chk(v == 0, "R3 bad key", v, 0);
    unlock(); wr(4, 0); wr(2, 16'h3333);
    rd(2, v); chk(v == 0, "R3 other write relocks", v, 0);
    unlock();
    rd(1, v); chk(v == 4, "R12 lock-open bit", v, 4);
    wr(2, 16'h4444);
    rd(2, v); chk(v == 16'h4444, "R4 open write", v, 16'h4444);
    rd(1, v); chk(v == 0, "R12 lock closed after write", v, 0);
    wr(2, 16'h5555);
    rd(2, v); chk(v == 16'h4444, "R4 second write ignored", v, 16'h4444);
  endtask

  task automatic t_clamp();
    int v;
    pwr(3, 15);
    rd(3, v); chk(v == 12, "R5 clamp", v, 12);
    pwr(3, 16'hFFFF);
    rd(3, v); chk(v == 12, "R5 clamp wide", v, 12);
    pwr(3, 12);
  endtask

  task automatic t_main();
    int v;
    pwr(1, 1); wr(4, 0);
    set_rel_match(5, 0);
    run_ticks(40);
    chk(first_irq == 5, "R6 R7 first event", first_irq, 5);
    chk(first_rst == 37, "R8 reset timing", first_rst, 37);
    chk(n_rst == 1, "R8 single pulse", n_rst, 1);
    rd(1, v); chk(v == 16'h9, "R12 ctrl after reset pulse", v, 9);
  endtask

  task automatic t_masked();
    pwr(1, 3); wr(4, 0);
    set_rel_match(7, 0);
    run_ticks(42);
    chk(first_irq == -1, "R7 masked irq", first_irq, -1);
    chk(first_rst == 39, "R8 reset despite mask", first_rst, 39);
  endtask

  task automatic t_clear();
    int v;
    pwr(1, 1); wr(4, 0);
    set_rel_match(4, 0);
    run_ticks(4);
    chk(irq == 1'b1, "R7 irq set", int'(irq), 1);
    rd(1, v); chk(v == 16'h19, "R12 ctrl one event", v, 16'h19);
    wr(4, 16'hBEEF);
    rd(1, v); chk(v == 1, "R9 clear", v, 1);
    chk(irq == 1'b0, "R9 irq low", int'(irq), 0);
    run_ticks(50);
    chk(first_rst == 48, "R9 countdown restarted", first_rst, 48);
  endtask

  task automatic t_disabled();
    int v;
    pwr(1, 0); wr(4, 0);
    set_rel_match(2, 0);
    run_ticks(40);
    chk(first_irq == -1 && n_rst == 0, "R10 quiet", n_rst, 0);
    rd(1, v); chk(v == 0, "R10 no events", v, 0);
  endtask

  task automatic t_wrap();
    pwr(1, 1); wr(4, 0);
    set_rel_match(3, 16'hF000);
    run_ticks(4);
    chk(first_irq == 3, "R6 upper bits ignored", first_irq, 3);
    pwr(3, 8); wr(4, 0);
    set_rel_match(250, 0);
    run_ticks(252);
    chk(first_irq == 250, "R11 wrap offset", first_irq, 250);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_lock();
    t_clamp();
    t_main();
    t_masked();
    t_clear();
    t_disabled();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule